// File: doc/BRIEF.md
# Grouped Interrupt Event Controller

This block collects up to 32 event flags into a pending register, qualifies them with an enable register, and drives three level-sensitive interrupt lines: one for transmit, one for receive and one for error. Event sources inside the chip raise flags through a vector of per-bit set strobes. Software reads both registers through a simple select-and-read port. It acknowledges events by writing ones to the pending register and reprograms the enables with a plain write.

Each interrupt line covers its own group of flag bits. The three groups are fixed by parameters and must be disjoint. A flag counts towards its line only while it is both pending and enabled. The lines are registered, so each one follows a register change one clock later. A change to the enables alone re-evaluates the lines in the same way as a change to the flags.

Top module: `irq_group_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises, both registers read 0 and `irq_tx`, `irq_rx` and `irq_err` are 0.
- R2: A write with `reg_sel` = 0 (pending register) clears every pending bit whose `wr_data` bit is 1 and leaves every bit whose `wr_data` bit is 0 unchanged.
- R3: A write with `reg_sel` = 1 (enable register) loads `wr_data` unchanged. Without a write, the enable register holds its value.
- R4: A 1 on bit i of `ev_set` sets pending bit i at the next clock edge. Other bits are not touched.
- R5: When a set strobe and a software clear hit the same bit in one cycle, the bit ends up set.
- R6: A pending bit whose enable bit is 0 raises no interrupt line.
- R7: With default parameters, bits 7:0 form the transmit group, bits 15:8 the receive group and bits 23:16 the error group. Each line is the OR of the bits in its group that are both pending and enabled. Bits 31:24 belong to no group and raise no line.
- R8: Each line changes exactly one clock after the register change that causes it. This includes a change to the enable register alone.
- R9: `rd_data` shows the pending register when `rd_sel` = 0 and the enable register when `rd_sel` = 1. A write to one register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register picked by `reg_sel` |
| reg_sel | input | 1 | Write target: 0 pending (write-one-to-clear), 1 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 pending, 1 enable |
| rd_data | output | 32 | Combinational read data |
| ev_set | input | 32 | Per-bit set strobes from event sources |
| irq_tx | output | 1 | Transmit group interrupt |
| irq_rx | output | 1 | Receive group interrupt |
| irq_err | output | 1 | Error group interrupt |

## Verification
Flags are raised in all three groups at once with every bit enabled, so that all lines must rise together. Single-group acknowledgements then show that each line follows only its own bits. Flags raised while enables are zero, and enables changed while no flag changes, separate the pending state from the qualified state. They also show that a mask-only change re-evaluates the lines after one clock. A strobe and a clear on the same bit in the same cycle tell apart set-wins from clear-wins. A flag in the ungrouped top byte checks that bits outside every group reach no line.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

   // number of grouped interrupt lines
   localparam int unsigned IRQG_N_GRP = 3;

   // order of the lines inside the grouped vectors
   typedef enum int unsigned {
      IRQG_TX  = 0,
      IRQG_RX  = 1,
      IRQG_ERR = 2
   } irqg_line_e;

   // register select encoding shared by read and write ports
   typedef enum logic {
      IRQG_SEL_PEND = 1'b0,
      IRQG_SEL_ENA  = 1'b1
   } irqg_sel_e;

endpackage

// File: rtl/irqg_pend_reg.sv
module irqg_pend_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   input  logic [W-1:0] set_bits,
   output logic [W-1:0] pend_q
);

   logic [W-1:0] after_clr;

   // software clear first, hardware set on top so a set is never lost
   always_comb begin
      after_clr = pend_q;
      if (clr_en) begin
         after_clr = pend_q & ~clr_bits;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         pend_q <= after_clr | set_bits;
      end
   end

   // every strobed bit is pending one cycle later, even under a clear
   AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_q & $past(set_bits)) == $past(set_bits))); // R5

   // a bit rises only through a strobe
   AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(set_bits)) == '0)); // R4

   // with no write, no bit falls
   AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clr_en)) |-> (($past(pend_q) & ~pend_q) == '0)); // R2

   // a bit falls only where a one was written
   AST_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(clr_en)) |-> (($past(pend_q) & ~pend_q & ~$past(clr_bits)) == '0)); // R2

endmodule

// File: rtl/irqg_ena_reg.sv
module irqg_ena_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_en,
   input  logic [W-1:0] ld_data,
   output logic [W-1:0] ena_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_q <= '0;
      end else if (ld_en) begin
         ena_q <= ld_data;
      end
   end

   AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(ld_en)) |-> $stable(ena_q)); // R3

   AST_ENA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ld_en)) |-> (ena_q == $past(ld_data))); // R3

endmodule

// File: rtl/irqg_line_out.sv
module irqg_line_out #(
   parameter int unsigned   W   = 32,
   parameter logic [W-1:0]  GRP = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] active,
   output logic         irq_q
);

   logic hit;

   generate
      if (GRP == '0) begin : g_empty
         // a group with no members never fires
         assign hit = 1'b0;
      end else begin : g_or
         assign hit = |(active & GRP);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= hit;
      end
   end

   // the line rises only one cycle after a qualified member bit
   AST_LINE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(rst_n) && (($past(active) & GRP) != '0))); // R7

   // a qualified member bit always shows on the line one cycle later
   AST_LINE_NOT_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rst_n)) && (($past(active) & GRP) != '0)) |-> irq_q); // R8

endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
   import irqg_pkg::*;
#(
   parameter int unsigned  W       = 32,
   parameter logic [W-1:0] TX_GRP  = 32'h0000_00FF,
   parameter logic [W-1:0] RX_GRP  = 32'h0000_FF00,
   parameter logic [W-1:0] ERR_GRP = 32'h00FF_0000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_wr,
   input  logic         reg_sel,
   input  logic [W-1:0] wr_data,
   input  logic         rd_sel,
   output logic [W-1:0] rd_data,
   input  logic [W-1:0] ev_set,
   output logic         irq_tx,
   output logic         irq_rx,
   output logic         irq_err
);

   localparam logic [IRQG_N_GRP-1:0][W-1:0] GRPS = {ERR_GRP, RX_GRP, TX_GRP};

   // elaboration-time parameter checks
   generate
      if (W < 1) begin : g_bad_width
         $error("irq_group_ctrl: W must be at least 1");
      end
      if (((TX_GRP & RX_GRP) | (TX_GRP & ERR_GRP) | (RX_GRP & ERR_GRP)) != '0) begin : g_bad_grp
         $error("irq_group_ctrl: interrupt groups overlap");
      end
   endgenerate

   logic [W-1:0]          pend_q;
   logic [W-1:0]          ena_q;
   logic [W-1:0]          active;
   logic [IRQG_N_GRP-1:0] irq_vec;
   logic                  wr_pend;
   logic                  wr_ena;

   assign wr_pend = reg_wr && (irqg_sel_e'(reg_sel) == IRQG_SEL_PEND);
   assign wr_ena  = reg_wr && (irqg_sel_e'(reg_sel) == IRQG_SEL_ENA);

   irqg_pend_reg #(.W(W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_en   (wr_pend),
      .clr_bits (wr_data),
      .set_bits (ev_set),
      .pend_q   (pend_q)
   );

   irqg_ena_reg #(.W(W)) u_ena (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (wr_ena),
      .ld_data (wr_data),
      .ena_q   (ena_q)
   );

   assign active = pend_q & ena_q;

   generate
      for (genvar g = 0; g < IRQG_N_GRP; g++) begin : g_line
         irqg_line_out #(.W(W), .GRP(GRPS[g])) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .active (active),
            .irq_q  (irq_vec[g])
         );
      end
   endgenerate

   assign irq_tx  = irq_vec[IRQG_TX];
   assign irq_rx  = irq_vec[IRQG_RX];
   assign irq_err = irq_vec[IRQG_ERR];

   assign rd_data = (irqg_sel_e'(rd_sel) == IRQG_SEL_ENA) ? ena_q : pend_q;

   // clearing flags never disturbs the enables
   AST_PEND_WR_KEEPS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_pend)) |-> $stable(ena_q)); // R9

   // a disabled flag never drives a line on its own
   AST_NO_LINE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ($past(ena_q) == '0)) |-> (irq_vec == '0)); // R6

endmodule

// File: tb/sim_irq_group_ctrl.sv
`timescale 1ns/1ps
module sim_irq_group_ctrl;

   localparam logic [31:0] TXG  = 32'h0000_00FF;
   localparam logic [31:0] RXG  = 32'h0000_FF00;
   localparam logic [31:0] ERRG = 32'h00FF_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [31:0] rd_data;
   logic [31:0] ev_set = '0;
   logic        irq_tx, irq_rx, irq_err;

   always #2.5 clk = ~clk;

   irq_group_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .ev_set(ev_set), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
   );

   typedef struct {
      int          due;
      int          kind;   // 0 rd_data, 1 tx, 2 rx, 3 err
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t       sb[$];
   int          cyc = 0;
   int          n_vec = 0;
   int          n_bad = 0;
   logic [31:0] m_pend = '0;
   logic [31:0] m_ena = '0;
   bit          done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare every item due at this falling edge
   always @(negedge clk) begin
      for (int i = sb.size() - 1; i >= 0; i--) begin
         if (sb[i].due == cyc) begin
            logic [31:0] act;
            case (sb[i].kind)
               0:       act = rd_data;
               1:       act = {31'b0, irq_tx};
               2:       act = {31'b0, irq_rx};
               default: act = {31'b0, irq_err};
            endcase
            n_vec++;
            if (act !== sb[i].exp) begin
               n_bad++;
               $display("FAIL %s kind=%0d actual=%h expected=%h cycle=%0d",
                        sb[i].req, sb[i].kind, act, sb[i].exp, cyc);
            end
            sb.delete(i);
         end
      end
   end

   task automatic push(int due, int kind, logic [31:0] exp, string req);
      item_t it;
      it.due = due; it.kind = kind; it.exp = exp; it.req = req;
      sb.push_back(it);
   endtask

   // one cycle of stimulus; read checks the state left by earlier steps
   task automatic step(bit wr, bit sel, logic [31:0] data, logic [31:0] set,
                       bit rsel, string req);
      @(posedge clk);
      #1;
      reg_wr = wr; reg_sel = sel; wr_data = data; ev_set = set; rd_sel = rsel;
      push(cyc, 0, rsel ? m_ena : m_pend, req);
      if (wr && !sel) m_pend = m_pend & ~data;
      m_pend = m_pend | set;
      if (wr && sel) m_ena = data;
      push(cyc + 2, 1, {31'b0, |(m_pend & m_ena & TXG)}, req);
      push(cyc + 2, 2, {31'b0, |(m_pend & m_ena & RXG)}, req);
      push(cyc + 2, 3, {31'b0, |(m_pend & m_ena & ERRG)}, req);
   endtask

   task automatic idle(int n, bit rsel, string req);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, rsel, req);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      // R1: values during reset
      repeat (3) @(posedge clk);
      @(negedge clk);
      n_vec++;
      if (rd_data !== 32'h0 || {irq_tx, irq_rx, irq_err} !== 3'b000) begin
         n_bad++;
         $display("FAIL R1 during reset actual=%h/%b expected=0/000",
                  rd_data, {irq_tx, irq_rx, irq_err});
      end
      @(posedge clk); #1; rst_n = 1'b1;
      idle(2, 1'b0, "R1");
      idle(2, 1'b1, "R1");
      // R6: flag pending with enables off raises nothing
      step(1'b0, 1'b0, '0, 32'h0000_0001, 1'b0, "R6");
      idle(3, 1'b0, "R6");
      // R3: load enables; R8 mask change alone raises tx one clock later
      step(1'b1, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, "R8");
      idle(2, 1'b1, "R3");
      // R4/R7: flags in all three groups
      step(1'b0, 1'b0, '0, 32'h0001_0202, 1'b0, "R4");
      idle(3, 1'b0, "R7");
      // R2: acknowledge the transmit bits only
      step(1'b1, 1'b0, 32'h0000_0003, '0, 1'b0, "R2");
      idle(3, 1'b0, "R2");
      // R9: enable register survived the flag write
      idle(1, 1'b1, "R9");
      // R8: enables narrowed, error line drops with no flag change
      step(1'b1, 1'b1, 32'h0000_FFFF, '0, 1'b1, "R8");
      idle(3, 1'b1, "R8");
      step(1'b1, 1'b1, 32'hFFFF_FFFF, '0, 1'b0, "R8");
      idle(3, 1'b0, "R9");
      // R5: strobe and clear on bit 5 in the same cycle
      step(1'b1, 1'b0, 32'h0000_0020, 32'h0000_0020, 1'b0, "R5");
      idle(3, 1'b0, "R5");
      // R7: ungrouped top byte raises no line
      step(1'b1, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, "R7");
      idle(3, 1'b0, "R7");
      step(1'b1, 1'b0, 32'h8000_0000, '0, 1'b0, "R2");
      idle(3, 1'b0, "R2");
      // R9: enable write leaves flags unchanged
      step(1'b0, 1'b0, '0, 32'h0000_4000, 1'b0, "R9");
      step(1'b1, 1'b1, 32'h0000_0000, '0, 1'b0, "R9");
      idle(3, 1'b0, "R9");
      idle(1, 1'b1, "R3");
      repeat (4) @(posedge clk);
      summary();
   end

endmodule